// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises a processor by counting slow ticks, nominally 1024 per second, that arrive as a one-cycle enable on the system clock. Software must clear the counter before it reaches the end of the selected period. A static run enable starts or stops the count. A three-bit period select picks one of eight terminal counts. A mode select chooses between two modes. In free-clear mode, a clear is accepted at any count. A missed period first raises an interrupt pulse, and a second missed period in a row raises a reset pulse. In windowed mode, a missed period raises a reset pulse at once. A clear that comes too early in the period also raises a reset pulse, with a cause of its own.

Every reset pulse records a two-bit cause code. The code keeps its first non-zero value until the block's own reset. Mode and period settings are taken into the running configuration only at safe points. A misbehaving program therefore cannot shorten or relax the supervision in the middle of a period.

Top module: `supervisor_wdt`

## Requirements
- R1: Period select values 0 to 7 give terminal counts of 8, 16, 32, 64, 128, 512, 2048 and 8192 ticks (with the default tick scaling). Starting from a zero count, the overflow occurs on that numbered tick.
- R2: In free-clear mode (mode select 0), a clear request is accepted at any count value and zeroes the counter.
- R3: In free-clear mode, the first overflow gives a one-cycle irq_pulse, and counting restarts from zero.
- R4: In free-clear mode, a second overflow with no accepted clear since the first gives a one-cycle rst_pulse with cause code 2'b01.
- R5: An accepted clear disarms the escalation, so the next overflow gives irq_pulse again and not rst_pulse.
- R6: In windowed mode (mode select 1), an overflow gives rst_pulse with cause code 2'b10 and never gives irq_pulse.
- R7: In windowed mode, a clear while the count is below half the terminal count gives rst_pulse with cause code 2'b11. A clear at or above half is accepted.
- R8: While run_en is low, the counter stays at zero, ticks and clear requests have no effect, and no pulse is produced.
- R9: While the counter runs, new period or mode select values take effect only at the next accepted clear or reset event. While run_en is low, and until the first tick after reset, the settings follow the inputs.
- R10: A clear request on a cycle without a tick is applied at that clock edge. On a cycle with both a clear and an overflowing tick, the clear takes priority and the overflow is dropped.
- R11: The cause code is 2'b00 after reset. It takes the cause of the first reset event and keeps that value through later events until rst_n is asserted.
- R12: After reset both pulses are low, and irq_pulse and rst_pulse are never high on the same cycle. Each pulse appears on the cycle after the edge that sampled its triggering tick or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count enable from the slow time base |
| run_en | input | 1 | Static enable; low holds the watchdog idle |
| win_mode | input | 1 | 0 = free-clear mode, 1 = windowed mode |
| period_sel | input | 3 | Terminal count select |
| clr_req | input | 1 | One-cycle clear request from software |
| irq_pulse | output | 1 | One-cycle warning interrupt |
| rst_pulse | output | 1 | One-cycle reset request |
| cause | output | 2 | Sticky cause code of the first reset event |

## Verification
The assertions check four properties on every cycle. The two pulses never coincide. A low run_en silences both pulses. A reset pulse always comes with a non-zero cause, and a non-zero cause never changes. They also check that the count stays within the active terminal count, that an accepted clear zeroes it, and that an interrupt never comes from windowed mode. Other behaviours can only be shown by the bench's scenarios. These are the exact tick on which each period overflows, the two-stage escalation and its re-arming by a clear, and the half-period boundary of the window. The bench also covers the deferred adoption of new settings and the priority of a clear over a coincident overflow.

// File: rtl/swdt_pkg.sv
package swdt_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE      = 2'b00,
      CAUSE_ESCALATE  = 2'b01,
      CAUSE_WIN_OVF   = 2'b10,
      CAUSE_BAD_CLEAR = 2'b11
   } cause_e;

   localparam int NUM_PERIODS = 8;
   localparam int SEL_W       = 3;
   localparam int SPAN_EXTRA  = 10;   // largest shift above the base
endpackage

// File: rtl/swdt_limit.sv
// Maps the period select onto the last count value and the window boundary.
module swdt_limit
   import swdt_pkg::*;
#(
   parameter int BASE_LOG2 = 3,
   parameter int CNT_W     = BASE_LOG2 + SPAN_EXTRA + 1
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] last,
   output logic [CNT_W-1:0] half
);
   logic [CNT_W-1:0] span [NUM_PERIODS];

   // Short periods double per step, the long ones quadruple.
   for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_span
      localparam int SH = (g < 5) ? (g + BASE_LOG2) : (2 * g - 4 + BASE_LOG2);
      if (SH >= CNT_W) begin : g_bad
         $error("swdt_limit: counter too narrow for period %0d", g);
      end
      assign span[g] = CNT_W'(1) << SH;
   end

   assign last = span[sel] - CNT_W'(1);
   assign half = span[sel] >> 1;
endmodule

// File: rtl/swdt_cfg.sv
// Holds the active period and mode; reloads only when asked.
module swdt_cfg
   import swdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             win_in,
   output logic [SEL_W-1:0] sel_q,
   output logic             win_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         win_q <= 1'b0;
      end else if (load) begin
         sel_q <= sel_in;
         win_q <= win_in;
      end
   end
endmodule

// File: rtl/swdt_engine.sv
// Counter, escalation state, window check and event outputs.
module swdt_engine
   import swdt_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             tick,
   input  logic             clr_req,
   input  logic             win_q,
   input  logic [CNT_W-1:0] last,
   input  logic [CNT_W-1:0] half,
   output logic             load_cfg,
   output logic             accept,
   output logic [CNT_W-1:0] count,
   output logic             irq_pulse,
   output logic             rst_pulse,
   output logic [1:0]       cause
);
   logic [CNT_W-1:0] count_q, count_n;
   logic             armed_q, armed_n;
   logic             fresh_q, fresh_n;
   logic             irq_n, evt;
   cause_e           cause_q, cause_n, evt_cause;

   always_comb begin
      count_n   = count_q;
      armed_n   = armed_q;
      fresh_n   = fresh_q;
      irq_n     = 1'b0;
      evt       = 1'b0;
      evt_cause = CAUSE_NONE;
      accept    = 1'b0;
      if (!run_en) begin
         count_n = '0;
         armed_n = 1'b0;
         fresh_n = 1'b1;
      end else if (clr_req) begin
         count_n = '0;
         armed_n = 1'b0;
         if (win_q && (count_q < half)) begin
            evt       = 1'b1;
            evt_cause = CAUSE_BAD_CLEAR;
         end else begin
            accept = 1'b1;
         end
      end else if (tick) begin
         fresh_n = 1'b0;
         if (count_q == last) begin
            count_n = '0;
            if (win_q) begin
               evt       = 1'b1;
               evt_cause = CAUSE_WIN_OVF;
            end else if (armed_q) begin
               evt       = 1'b1;
               evt_cause = CAUSE_ESCALATE;
               armed_n   = 1'b0;
            end else begin
               irq_n   = 1'b1;
               armed_n = 1'b1;
            end
         end else begin
            count_n = count_q + CNT_W'(1);
         end
      end
      cause_n = (cause_q == CAUSE_NONE && evt) ? evt_cause : cause_q;
   end

   assign load_cfg = fresh_q || !run_en || accept || evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q   <= '0;
         armed_q   <= 1'b0;
         fresh_q   <= 1'b1;
         cause_q   <= CAUSE_NONE;
         irq_pulse <= 1'b0;
         rst_pulse <= 1'b0;
      end else begin
         count_q   <= count_n;
         armed_q   <= armed_n;
         fresh_q   <= fresh_n;
         cause_q   <= cause_n;
         irq_pulse <= irq_n;
         rst_pulse <= evt;
      end
   end

   assign count = count_q;
   assign cause = cause_q;
endmodule

// File: rtl/supervisor_wdt.sv
module supervisor_wdt
   import swdt_pkg::*;
#(
   parameter int BASE_LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_en,
   input  logic             win_mode,
   input  logic [SEL_W-1:0] period_sel,
   input  logic             clr_req,
   output logic             irq_pulse,
   output logic             rst_pulse,
   output logic [1:0]       cause
);
   localparam int CNT_W = BASE_LOG2 + SPAN_EXTRA + 1;

   if (BASE_LOG2 < 1 || BASE_LOG2 > 12) begin : g_param_bad
      $error("supervisor_wdt: BASE_LOG2 out of range");
   end

   logic [SEL_W-1:0] cfg_sel;
   logic             cfg_win;
   logic             load_cfg;
   logic             clr_ok;
   logic [CNT_W-1:0] last_cnt, half_cnt, count;

   swdt_cfg u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_cfg),
      .sel_in (period_sel),
      .win_in (win_mode),
      .sel_q  (cfg_sel),
      .win_q  (cfg_win)
   );

   swdt_limit #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_limit (
      .sel  (cfg_sel),
      .last (last_cnt),
      .half (half_cnt)
   );

   swdt_engine #(.CNT_W(CNT_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .tick      (tick),
      .clr_req   (clr_req),
      .win_q     (cfg_win),
      .last      (last_cnt),
      .half      (half_cnt),
      .load_cfg  (load_cfg),
      .accept    (clr_ok),
      .count     (count),
      .irq_pulse (irq_pulse),
      .rst_pulse (rst_pulse),
      .cause     (cause)
   );
endmodule

// File: rtl/supervisor_wdt_chk.sv
module supervisor_wdt_chk #(
   parameter int CNT_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             irq_pulse,
   input logic             rst_pulse,
   input logic [1:0]       cause,
   input logic             cfg_win,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] last,
   input logic             accept
);
   // R12
   pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_pulse && rst_pulse));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!irq_pulse && !rst_pulse));

   // R11
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cause != 2'b00) |=> $stable(cause));

   // R11
   cause_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> (cause != 2'b00));

   // R6
   no_window_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !cfg_win);

   // R1
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= last);

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (count == '0));
endmodule

bind supervisor_wdt supervisor_wdt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .irq_pulse (irq_pulse),
   .rst_pulse (rst_pulse),
   .cause     (cause),
   .cfg_win   (cfg_win),
   .count     (count),
   .last      (last_cnt),
   .accept    (clr_ok)
);

// File: tb/supervisor_wdt_test.sv
`timescale 1ns/1ps
module supervisor_wdt_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       run_en = 1'b1;
   logic       win_mode = 1'b0;
   logic [2:0] period_sel = 3'd0;
   logic       clr_req = 1'b0;
   logic       irq_pulse, rst_pulse;
   logic [1:0] cause;

   int checks = 0;
   int fails  = 0;
   int irq_seen = 0;
   int rst_seen = 0;
   int i0, r0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   supervisor_wdt uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en),
      .win_mode(win_mode), .period_sel(period_sel), .clr_req(clr_req),
      .irq_pulse(irq_pulse), .rst_pulse(rst_pulse), .cause(cause)
   );

   always @(negedge clk) begin
      if (irq_pulse) irq_seen++;
      if (rst_pulse) rst_seen++;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic snap();
      #1;
      i0 = irq_seen;
      r0 = rst_seen;
   endtask

   task automatic expect_events(input string req, input int irq_exp, input int rst_exp);
      #1;
      chk({req, " irq count"}, irq_seen - i0, irq_exp);
      chk({req, " rst count"}, rst_seen - r0, rst_exp);
      i0 = irq_seen;
      r0 = rst_seen;
   endtask

   task automatic do_reset(input logic win, input logic [2:0] sel);
      @(negedge clk);
      rst_n = 1'b0; win_mode = win; period_sel = sel;
      tick = 1'b0; clr_req = 1'b0; run_en = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      snap();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
      end
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear();
      clr_req = 1'b1;
      @(negedge clk);
      clr_req = 1'b0;
      @(negedge clk);
   endtask

   // R12 R11: reset state
   task automatic t_reset_state();
      do_reset(1'b0, 3'd0);
      chk("R12 irq after reset", int'(irq_pulse), 0);
      chk("R12 rst after reset", int'(rst_pulse), 0);
      chk("R11 cause after reset", int'(cause), 0);
   endtask

   // R1: period lengths
   task automatic t_period(input logic [2:0] sel, input int len);
      do_reset(1'b0, sel);
      ticks(len - 1);
      expect_events("R1 before terminal", 0, 0);
      ticks(1);
      expect_events("R1 at terminal", 1, 0);
   endtask

   // R3 R4: two-stage escalation
   task automatic t_escalate();
      do_reset(1'b0, 3'd0);
      ticks(8);
      expect_events("R3 first overflow", 1, 0);
      ticks(7);
      expect_events("R3 restart from zero", 0, 0);
      ticks(1);
      expect_events("R4 second overflow", 0, 1);
      chk("R4 cause escalate", int'(cause), 1);
   endtask

   // R2 R5: clear anywhere and re-arm
   task automatic t_rearm();
      do_reset(1'b0, 3'd0);
      ticks(8);
      expect_events("R5 warning", 1, 0);
      ticks(2);
      clear();
      expect_events("R2 clear accepted", 0, 0);
      ticks(7);
      expect_events("R2 counter zeroed", 0, 0);
      ticks(1);
      expect_events("R5 irq again", 1, 0);
      chk("R5 cause none", int'(cause), 0);
   endtask

   // R6: windowed overflow
   task automatic t_win_overflow();
      do_reset(1'b1, 3'd0);
      ticks(7);
      expect_events("R6 before terminal", 0, 0);
      ticks(1);
      expect_events("R6 overflow reset", 0, 1);
      chk("R6 cause window", int'(cause), 2);
   endtask

   // R7: window boundary
   task automatic t_window_clear();
      do_reset(1'b1, 3'd0);
      ticks(3);
      clear();
      expect_events("R7 early clear", 0, 1);
      chk("R7 cause bad clear", int'(cause), 3);
      do_reset(1'b1, 3'd0);
      ticks(4);
      clear();
      expect_events("R7 clear at half", 0, 0);
      ticks(7);
      expect_events("R7 restarted", 0, 0);
      ticks(1);
      expect_events("R7 overflow after legal clear", 0, 1);
   endtask

   // R8: disabled
   task automatic t_disabled();
      do_reset(1'b0, 3'd0);
      run_en = 1'b0;
      ticks(40);
      clear();
      expect_events("R8 idle", 0, 0);
      chk("R8 cause idle", int'(cause), 0);
      run_en = 1'b1;
      @(negedge clk);
      ticks(7);
      expect_events("R8 counter held zero", 0, 0);
      ticks(1);
      expect_events("R8 runs after enable", 1, 0);
   endtask

   // R9: deferred settings
   task automatic t_defer();
      do_reset(1'b0, 3'd0);
      ticks(3);
      period_sel = 3'd1;
      ticks(5);
      expect_events("R9 old period kept", 1, 0);
      clear();
      ticks(15);
      expect_events("R9 new period pending", 0, 0);
      ticks(1);
      expect_events("R9 new period used", 1, 0);
      do_reset(1'b0, 3'd0);
      ticks(2);
      win_mode = 1'b1;
      ticks(6);
      expect_events("R9 old mode kept", 1, 0);
      clear();
      ticks(8);
      expect_events("R9 new mode used", 0, 1);
      chk("R9 cause window", int'(cause), 2);
      // R11: second event keeps first cause
      clear();
      expect_events("R11 second event", 0, 1);
      chk("R11 cause sticky", int'(cause), 2);
   endtask

   // R10: clear timing and priority
   task automatic t_clear_timing();
      do_reset(1'b0, 3'd0);
      ticks(5);
      clear();
      ticks(7);
      expect_events("R10 non-tick clear", 0, 0);
      ticks(1);
      expect_events("R10 overflow after clear", 1, 0);
      clear();
      ticks(7);
      tick = 1'b1; clr_req = 1'b1;
      @(negedge clk);
      tick = 1'b0; clr_req = 1'b0;
      @(negedge clk);
      expect_events("R10 clear beats overflow", 0, 0);
      ticks(7);
      expect_events("R10 counter zero after tie", 0, 0);
      ticks(1);
      expect_events("R10 irq after tie", 1, 0);
   endtask

   initial begin
      t_reset_state();
      t_period(3'd0, 8);
      t_period(3'd3, 64);
      t_period(3'd5, 512);
      t_period(3'd7, 8192);
      t_escalate();
      t_rearm();
      t_win_overflow();
      t_window_clear();
      t_disabled();
      t_defer();
      t_clear_timing();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule